// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal request port and the pins of an external asynchronous static RAM of 128K bytes. A client presents one read or one write at a time with a valid/ready handshake. The controller turns it into a timed pin sequence on a 17-bit address, a low-active select and a high-active select, a low-active output enable, a low-active write strobe, and an 8-bit data bus. The bus is split into output value, output enable and input value, so the pad ring can build the tri-state buffer.

The length of every phase is counted in system clocks. Each count comes from a nanosecond timing parameter and the clock-period parameter: the ceiling of the quotient, never less than one clock. Writes are ended by the write strobe, and output enable stays high throughout them. The controller turns on its own data drivers only after the memory has had time to float the bus. Every read is followed by a turnaround phase that gives the memory time to release the bus. Read data comes back with a single-cycle valid pulse, and a write finishes with a single-cycle done pulse.

Top module: `asram_bridge`

## Requirements
- R1: While reset is asserted (asynchronous, active low) and right after it, memCe1N=1, memCe2=0, memOeN=1, memWeN=1, memDqOe=0 and reqReady=1. This holds even when reset arrives in the middle of a cycle.
- R2: reqReady is high only in the idle state. A request presented while the controller is busy is ignored and causes no memory cycle.
- R3: A read holds memCe1N=0, memCe2=1, memWeN=1 and memOeN=0 for ACC clocks, where ACC = max(ceil(tAA), ceil(tDOE)). memDqIn is captured on the last of those clocks. It is returned on rspRdata together with a rspRdValid pulse exactly one clock long.
- R4: memOeN stays 1 in every clock of a write cycle.
- R5: memWeN is low for PULSE clocks, the largest of ceil(tPWE), ceil(tAW) minus SETUP, and HZ + ceil(tSD). Its fall comes SETUP = ceil(tSA) clocks after the select lines assert.
- R6: memDqOe rises only after memWeN has been low for HZ = ceil(tHZWE) full clocks. It stays high until exactly one clock after memWeN returns high, so that data is held on the bus across the write-ending edge.
- R7: After rspRdValid, the controller stays busy for TURN = ceil(tHZOE) clocks in total, counting the clock of the pulse. During that time memOeN=1, memDqOe=0 and the memory is deselected. The controller never drives the bus while the memory may still be driving it.
- R8: A write produces one rspWrDone pulse, one clock long, in the last clock of the cycle. The byte on the data bus is stored at the address of the request.
- R9: Whenever reqReady is high, the memory is deselected (memCe1N=1, memCe2=0).
- R10: memAddr stays constant in every clock in which the memory is selected. It holds the request address, including the lowest and highest word addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request taken this clock |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 8 | Write byte |
| rspRdValid | output | 1 | One-clock pulse, read data valid |
| rspRdata | output | 8 | Read byte |
| rspWrDone | output | 1 | One-clock pulse, write finished |
| memAddr | output | 17 | Address pins |
| memCe1N | output | 1 | Select, active low |
| memCe2 | output | 1 | Select, active high |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memDqOut | output | 8 | Data bus value to drive |
| memDqOe | output | 1 | Data bus driver enable |
| memDqIn | input | 8 | Data bus value seen at the pins |

## Verification
The bench builds the block with its default parameters: a 10 ns clock and the 70 ns grade timings. That gives SETUP=1, PULSE=6, HZ=3, a one-clock hold, ACC=7 and TURN=3, so every phase lasts several clocks and the driver delay falls inside the strobe. At this ratio the bench's memory model, which keeps time in nanoseconds, can tell premature read sampling from a correct capture. It can also catch data setup shorter than required before the strobe rises, and a driver that switches on while the memory may still be driving.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD,
    PH_RACCESS,
    PH_RTURN
  } phase_e;

  // Strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic load;    // capture request address and data
    logic select;  // memory selected
    logic outEn;   // memory output enable
    logic wrEn;    // write strobe
    logic drive;   // controller drives data bus
    logic sample;  // capture read data
  } strobe_t;

  function automatic int clocksFor(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int SETUP_CLK = 1,
  parameter int PULSE_CLK = 6,
  parameter int HZ_CLK    = 3,
  parameter int HOLD_CLK  = 1,
  parameter int ACC_CLK   = 7,
  parameter int TURN_CLK  = 3,
  parameter int CNT_W     = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output logic    wrDone,
  output strobe_t strb
);

  phase_e            state, stateNext;
  logic [CNT_W-1:0]  cnt, cntNext, lastCnt;
  logic              lastClk;

  always_comb begin
    case (state)
      PH_WSETUP:  lastCnt = CNT_W'(SETUP_CLK - 1);
      PH_WPULSE:  lastCnt = CNT_W'(PULSE_CLK - 1);
      PH_WHOLD:   lastCnt = CNT_W'(HOLD_CLK - 1);
      PH_RACCESS: lastCnt = CNT_W'(ACC_CLK - 1);
      PH_RTURN:   lastCnt = CNT_W'(TURN_CLK - 1);
      default:    lastCnt = '0;
    endcase
  end

  assign lastClk = (cnt == lastCnt);

  always_comb begin
    stateNext = state;
    cntNext   = cnt + 1'b1;
    case (state)
      PH_IDLE: begin
        cntNext = '0;
        if (reqValid) stateNext = reqWrite ? PH_WSETUP : PH_RACCESS;
      end
      PH_WSETUP:  if (lastClk) begin stateNext = PH_WPULSE;  cntNext = '0; end
      PH_WPULSE:  if (lastClk) begin stateNext = PH_WHOLD;   cntNext = '0; end
      PH_WHOLD:   if (lastClk) begin stateNext = PH_IDLE;    cntNext = '0; end
      PH_RACCESS: if (lastClk) begin stateNext = PH_RTURN;   cntNext = '0; end
      PH_RTURN:   if (lastClk) begin stateNext = PH_IDLE;    cntNext = '0; end
      default: begin stateNext = PH_IDLE; cntNext = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strb.load   = (state == PH_IDLE) && reqValid;
    strb.select = (state == PH_WSETUP) || (state == PH_WPULSE) ||
                  (state == PH_WHOLD)  || (state == PH_RACCESS);
    strb.outEn  = (state == PH_RACCESS);
    strb.wrEn   = (state == PH_WPULSE);
    strb.drive  = ((state == PH_WPULSE) && (cnt >= CNT_W'(HZ_CLK))) ||
                  ((state == PH_WHOLD) && (cnt == '0));
    strb.sample = (state == PH_RACCESS) && lastClk;
  end

  assign reqReady = (state == PH_IDLE);
  assign wrDone   = (state == PH_WHOLD) && lastClk;

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady) else $error("ready stayed high");  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone) else $error("done longer than one clock");          // R8
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !strb.select) else $error("selected while idle");          // R9

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspRdValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rdataQ   <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.sample) rdataQ <= memDqIn;
      rdValidQ <= strb.sample;
    end
  end

  assign memAddr    = addrQ;
  assign memCe1N    = !strb.select;
  assign memCe2     = strb.select;
  assign memOeN     = !strb.outEn;
  assign memWeN     = !strb.wrEn;
  assign memDqOut   = wdataQ;
  assign memDqOe    = strb.drive;
  assign rspRdata   = rdataQ;
  assign rspRdValid = rdValidQ;

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspRdValid |=> !rspRdValid) else $error("read valid too long");         // R3
  AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN) else $error("output enable during write");          // R4
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && memWeN) |=> !memDqOe) else $error("driver held too long");  // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && $past(!memCe1N)) |-> $stable(memAddr)) else $error("address moved"); // R10

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/1ps
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 70,
  parameter int T_PWE_NS  = 55,
  parameter int T_AW_NS   = 60,
  parameter int T_SD_NS   = 30,
  parameter int T_SA_NS   = 0,
  parameter int T_HZWE_NS = 25,
  parameter int T_AA_NS   = 70,
  parameter int T_DOE_NS  = 35,
  parameter int T_HZOE_NS = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspRdValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspWrDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int SETUP_CLK = clocksFor(T_SA_NS, CLK_NS);
  localparam int HZ_CLK    = clocksFor(T_HZWE_NS, CLK_NS);
  localparam int PULSE_CLK = maxOf(maxOf(clocksFor(T_PWE_NS, CLK_NS),
                                         clocksFor(T_AW_NS, CLK_NS) - SETUP_CLK),
                                   HZ_CLK + clocksFor(T_SD_NS, CLK_NS));
  localparam int HOLD_CLK  = maxOf(1, clocksFor(T_WC_NS, CLK_NS) - SETUP_CLK - PULSE_CLK);
  localparam int ACC_CLK   = maxOf(clocksFor(T_AA_NS, CLK_NS), clocksFor(T_DOE_NS, CLK_NS));
  localparam int TURN_CLK  = clocksFor(T_HZOE_NS, CLK_NS);
  localparam int MAX_CLK   = maxOf(maxOf(maxOf(SETUP_CLK, PULSE_CLK), maxOf(HOLD_CLK, ACC_CLK)),
                                   TURN_CLK);
  localparam int CNT_W     = $clog2(MAX_CLK + 1);

  strobe_t strb;

  asram_ctrl #(
    .SETUP_CLK(SETUP_CLK), .PULSE_CLK(PULSE_CLK), .HZ_CLK(HZ_CLK),
    .HOLD_CLK(HOLD_CLK), .ACC_CLK(ACC_CLK), .TURN_CLK(TURN_CLK), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .wrDone(rspWrDone), .strb(strb)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspRdValid(rspRdValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

endmodule

// File: tb/test_asram_bridge.sv
`timescale 1ns/1ps
module test_asram_bridge;

  // Expected phase lengths at 10 ns clock, 70 ns grade (from the requirements)
  localparam int EXP_PULSE = 6;  // R5: max(6, 6-1, 3+3)
  localparam int EXP_HZ    = 3;  // R6
  localparam int EXP_ACC   = 7;  // R3: max(7, 4)
  localparam int EXP_TURN  = 3;  // R7

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspRdValid, rspWrDone;
  logic [7:0]  rspRdata;
  logic [16:0] memAddr;
  logic        memCe1N, memCe2, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut, memDqIn;

  int nChecks = 0, nErrors = 0, contention = 0;

  always #5 clk = ~clk;

  asram_bridge i_asram_bridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspRdValid(rspRdValid), .rspRdata(rspRdata), .rspWrDone(rspWrDone),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2), .memOeN(memOeN),
    .memWeN(memWeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // ---------------- memory model with nanosecond timing ----------------
  logic [7:0] memArr [int];
  logic       modelDrive = 1'b0;
  logic [7:0] modelData = 8'h00;
  realtime    rdStart = 0, oeRise = -1000, drvStart = -1000;

  function automatic logic [7:0] look(input logic [16:0] a);
    return memArr.exists(int'(a)) ? memArr[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!memCe1N && memCe2 && !memOeN && memWeN) begin
      if (!modelDrive) rdStart = $realtime;
      modelDrive = 1'b1;
      // half-clock granularity: data valid counted from the first observation
      modelData = (($realtime - rdStart) >= 60.0) ? look(memAddr) : ~look(memAddr);
    end else begin
      modelDrive = 1'b0;
    end
  end

  always @(posedge memOeN) oeRise = $realtime;

  always @(posedge memDqOe) begin
    drvStart = $realtime;
    if (modelDrive || (($realtime - oeRise) < 25.0)) contention++;
  end

  always @(posedge memWeN) begin
    if (memCe1N === 1'b0 && memCe2 === 1'b1) begin
      if (memDqOe && (($realtime - drvStart) >= 29.99)) memArr[int'(memAddr)] = memDqOut;
      else memArr[int'(memAddr)] = 8'hA5;
    end
  end

  assign memDqIn = modelDrive ? modelData : (memDqOe ? memDqOut : 8'h00);

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [16:0] a, input logic [7:0] d);
    int weLow = 0, drv = 0, firstDrv = -1, drvAfter = 0, oeBad = 0;
    int done = 0, addrBad = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R2 ready before write", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (reqReady) break;
      if (!memWeN) weLow++;
      if (memDqOe) begin
        drv++;
        if (firstDrv < 0) firstDrv = weLow;
        if (memWeN) drvAfter++;
      end
      if (!memOeN) oeBad++;
      if (!memCe1N && memAddr != a) addrBad++;
      if (rspWrDone) done++;
      @(negedge clk);
    end
    check(weLow == EXP_PULSE, "R5 write strobe length", weLow, EXP_PULSE);
    check(firstDrv == EXP_HZ + 1, "R6 driver start", firstDrv, EXP_HZ + 1);
    check(drvAfter == 1, "R6 driver after strobe", drvAfter, 1);
    check(oeBad == 0, "R4 output enable in write", oeBad, 0);
    check(done == 1, "R8 done pulse count", done, 1);
    check(addrBad == 0, "R10 address during write", addrBad, 0);
    check(memCe1N == 1'b1 && memCe2 == 1'b0, "R9 deselect when idle", int'(memCe2), 0);
  endtask

  task automatic doRead(input logic [16:0] a, input logic [7:0] exp, input bit poke);
    int oeLow = 0, selBad = 0, vld = 0, turn = 0, turnBad = 0, addrBad = 0, busyReady = 0;
    logic [7:0] got = 8'h00;
    bit seen = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R2 ready before read", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (reqReady) break;
      if (poke && i < 3) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = ~exp;
        if (reqReady) busyReady++;
      end else reqValid = 1'b0;
      if (!memOeN) begin
        oeLow++;
        if (memCe1N || !memCe2 || !memWeN) selBad++;
      end
      if (!memCe1N && memAddr != a) addrBad++;
      if (rspRdValid) begin vld++; got = rspRdata; seen = 1; end
      if (seen) begin
        turn++;
        if (!memOeN || memDqOe || !memCe1N) turnBad++;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(oeLow == EXP_ACC, "R3 access length", oeLow, EXP_ACC);
    check(selBad == 0, "R3 pin levels in read", selBad, 0);
    check(vld == 1, "R3 valid pulse count", vld, 1);
    check(got == exp, "R3 read data", int'(got), int'(exp));
    check(turn == EXP_TURN, "R7 turnaround length", turn, EXP_TURN);
    check(turnBad == 0, "R7 bus idle in turnaround", turnBad, 0);
    check(addrBad == 0, "R10 address during read", addrBad, 0);
    if (poke) check(busyReady == 0, "R2 ready while busy", busyReady, 0);
  endtask

  task automatic checkIdlePins(input string req);
    check(memCe1N == 1'b1 && memCe2 == 1'b0 && memOeN == 1'b1 && memWeN == 1'b1 &&
          memDqOe == 1'b0 && reqReady == 1'b1, req,
          int'({memCe1N, memCe2, memOeN, memWeN, memDqOe, reqReady}), 6'b101101);
  endtask

  task automatic testReset();
    #1;
    checkIdlePins("R1 pins in reset");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdlePins("R1 pins after reset");
  endtask

  task automatic testResetMidWrite();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h0BEEF; reqWdata = 8'h66;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(memWeN == 1'b0, "R1 strobe low before reset", int'(memWeN), 0);
    rstN = 1'b0;
    #1;
    checkIdlePins("R1 pins on reset mid write");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdlePins("R1 pins after mid write reset");
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    nErrors++;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    testReset();
    doWrite(17'h00000, 8'h3C);                 // R8 R10 lowest address
    doWrite(17'h1FFFF, 8'hC3);                 // R10 highest address
    doRead(17'h00000, 8'h3C, 1'b0);
    doRead(17'h1FFFF, 8'hC3, 1'b0);
    doWrite(17'h12345, 8'hA7);
    doRead(17'h12345, 8'hA7, 1'b1);            // R2 busy request ignored
    doRead(17'h12345, 8'hA7, 1'b0);            // R2 memory unchanged
    doWrite(17'h00F0F, 8'h5E);                 // write right after turnaround
    doRead(17'h00F0F, 8'h5E, 1'b0);
    testResetMidWrite();
    doWrite(17'h0AAAA, 8'h81);
    doRead(17'h0AAAA, 8'h81, 1'b0);
    check(contention == 0, "R7 bus contention", contention, 0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule